// File: doc/BRIEF.md
# Multi-level interrupt dispatch unit

This unit sits beside a processor's exception logic. When the core reaches a point where it may take an interrupt, it raises `eval_i` for one cycle and presents the pending interrupt level, the current interrupt level, the pending and enable masks, its PC, its status word and its run-time vector base. The unit checks whether the pending level qualifies. If it does, the unit records the interrupted context in its saved-context registers, produces the status word the core must adopt and a redirect PC, and classifies the event.

Levels 2 and above are high-priority interrupts. Each has its own saved-PC and saved-status register, and each vectors to its own handler. A level-1 interrupt is turned into an ordinary exception. It becomes a user exception, a kernel exception or a double exception, depending on the user-mode and exception-mode bits of the status word. It also writes a fixed cause code. Vector addresses are built from parameterized offsets. A parameter selects whether they are relocated against the run-time vector base or fixed to a default base. A second parameter selects whether a dedicated double-exception PC register exists.

Status word layout: bits [3:0] hold the interrupt level field, bit 4 is the exception-mode bit and bit 5 is the user-mode bit.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken on a cycle with `eval_i` high only when all three conditions hold. The pending level must be strictly greater than `cur_lvl_i`. It must be no greater than the parameter `NLVL`. The AND of `lvl_mask_i` slot L (bits [32L+31:32L]) with `pend_i` and `en_i` must be nonzero.
- R2: For a taken level L ≥ 2, the PC is stored in saved-PC slot L (`epc_o` bits [32(L-1)+31:32(L-1)]). The status word is stored in saved-status slot L (`eps_o` bits [32(L-2)+31:32(L-2)]).
- R3: For a taken level L ≥ 2, `ps_o` equals the input status word with bits [3:0] replaced by L and bit 4 set.
- R4: The redirect PC for level L ≥ 2 is base + `HI_VEC_OFS` + L·`HI_VEC_STRIDE`. The base is `vecbase_i` when `RELOC_EN`=1 and `DEF_VECBASE` otherwise.
- R5: A taken level-1 interrupt writes `L1_CAUSE` (default 4) into `cause_o`. High levels leave `cause_o` unchanged.
- R6: A level-1 interrupt taken with status bit 4 set is a double exception (class code 4). The PC is saved in `depc_o` when `HAS_DEPC`=1, and in saved-PC slot 1 otherwise.
- R7: A level-1 interrupt taken with status bit 4 clear saves the PC in saved-PC slot 1. It is a user exception (class 3) when status bit 5 is set, and a kernel exception (class 2) otherwise. High levels report class 1.
- R8: For every taken level-1 interrupt, `ps_o` equals the input status word with bit 4 set. The redirect PC is base + `KER_VEC_OFS`, `USR_VEC_OFS` or `DBL_VEC_OFS` for kernel, user or double, with the base chosen as in R4.
- R9: Outputs are registered, one cycle after the `eval_i` cycle. `taken_o` is high for exactly that one cycle per take. When no interrupt is taken, every saved register, `cause_o`, `ps_o`, `pc_o` and `class_o` keeps its value.
- R10: After reset, all saved registers, `cause_o`, `ps_o` and `pc_o` are zero, `class_o` is 0 (none) and `taken_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate the pending interrupt this cycle |
| lvl_i | input | 4 | Pending interrupt level |
| cur_lvl_i | input | 4 | Current interrupt level of the core |
| pend_i | input | 32 | Pending interrupt mask |
| en_i | input | 32 | Interrupt enable mask |
| lvl_mask_i | input | 32*(NLVL+1) | Per-level mask table, slot L at bits [32L+31:32L] |
| pc_i | input | 32 | PC of the interrupted context |
| ps_i | input | 32 | Status word of the interrupted context |
| vecbase_i | input | 32 | Run-time vector base |
| taken_o | output | 1 | One-cycle strobe: an interrupt was taken |
| class_o | output | 3 | 0 none, 1 high level, 2 kernel, 3 user, 4 double |
| ps_o | output | 32 | Status word to adopt |
| pc_o | output | 32 | Redirect PC |
| cause_o | output | 6 | Exception cause register |
| epc_o | output | 32*NLVL | Saved-PC registers for levels 1..NLVL |
| eps_o | output | 32*(NLVL-1) | Saved-status registers for levels 2..NLVL |
| depc_o | output | 32 | Double-exception PC register (zero if absent) |

## Verification
The assertions assume that the core keeps `eval_i` low during reset. They also assume that the mask table slot for level 0 is never relied on, since level 0 can never exceed a current level. The pending level is taken as a plain 4-bit value that may exceed `NLVL`.

The stimulus sweeps every pending level from 0 to 15 against current levels 0 to 7. Each combination is applied with its own status word, so the exception-mode and user-mode bits cycle through all four combinations. The sweep drives two instances, one with relocation and a double-exception PC register and one without either, so both variants of R4, R6 and R8 are exercised. Dedicated cases clear pending or enable bits so that the mask AND selects or rejects the interrupt on its own.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int PS_LVL_W   = 4;
  localparam int PS_EXCM_B  = 4;
  localparam int PS_UM_B    = 5;

  typedef enum logic [2:0] {
    XC_NONE   = 3'd0,
    XC_HIGH   = 3'd1,
    XC_KERNEL = 3'd2,
    XC_USER   = 3'd3,
    XC_DOUBLE = 3'd4
  } xclass_e;

  typedef struct packed {
    logic    take;
    xclass_e cls;
  } decision_t;

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_dispatch_pkg::*;
#(
  parameter int NLVL   = 6,
  parameter int LVL_W  = 4,
  parameter int MASK_W = 32
) (
  input  logic [LVL_W-1:0]           lvl_i,
  input  logic [LVL_W-1:0]           cur_lvl_i,
  input  logic [MASK_W*(NLVL+1)-1:0] tbl_i,
  input  logic [MASK_W-1:0]          pend_i,
  input  logic [MASK_W-1:0]          en_i,
  input  logic                       excm_i,
  input  logic                       um_i,
  output decision_t                  dec_o
);

  localparam int               TBL_N   = NLVL + 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLVL);
  localparam logic [LVL_W-1:0] ONE_LVL = LVL_W'(1);

  logic              above;
  logic              in_range;
  logic              hit;
  logic [MASK_W-1:0] sel_mask;

  assign above    = lvl_i > cur_lvl_i;
  assign in_range = lvl_i <= TOP_LVL;

  // slot lookup, guarded so an out-of-range level selects nothing
  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < TBL_N; i++) begin
      if (in_range && (lvl_i == LVL_W'(i))) begin
        sel_mask = tbl_i[MASK_W*i +: MASK_W];
      end
    end
  end

  assign hit = |(sel_mask & pend_i & en_i);

  always_comb begin
    dec_o.take = above && in_range && hit;
    dec_o.cls  = XC_NONE;
    if (dec_o.take) begin
      if (lvl_i > ONE_LVL)  dec_o.cls = XC_HIGH;
      else if (excm_i)      dec_o.cls = XC_DOUBLE;
      else if (um_i)        dec_o.cls = XC_USER;
      else                  dec_o.cls = XC_KERNEL;
    end
  end

endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
  import irq_dispatch_pkg::*;
#(
  parameter int          XLEN           = 32,
  parameter int          LVL_W          = 4,
  parameter bit          RELOC_EN       = 1'b1,
  parameter logic [31:0] DEF_VECBASE    = 32'h4000_0000,
  parameter logic [31:0] HI_VEC_OFS     = 32'h0000_0180,
  parameter logic [31:0] HI_VEC_STRIDE  = 32'h0000_0040,
  parameter logic [31:0] KER_VEC_OFS    = 32'h0000_0300,
  parameter logic [31:0] USR_VEC_OFS    = 32'h0000_0340,
  parameter logic [31:0] DBL_VEC_OFS    = 32'h0000_03C0
) (
  input  xclass_e          cls_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [XLEN-1:0]  vecbase_i,
  output logic [XLEN-1:0]  target_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ofs;

  generate
    if (RELOC_EN) begin : g_reloc
      assign base = vecbase_i;
    end else begin : g_fixed
      assign base = XLEN'(DEF_VECBASE);
    end
  endgenerate

  always_comb begin
    unique case (cls_i)
      XC_HIGH:   ofs = XLEN'(HI_VEC_OFS) + XLEN'(lvl_i) * XLEN'(HI_VEC_STRIDE);
      XC_KERNEL: ofs = XLEN'(KER_VEC_OFS);
      XC_USER:   ofs = XLEN'(USR_VEC_OFS);
      XC_DOUBLE: ofs = XLEN'(DBL_VEC_OFS);
      default:   ofs = '0;
    endcase
  end

  assign target_o = base + ofs;

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_dispatch_pkg::*;
#(
  parameter int NLVL     = 6,
  parameter int LVL_W    = 4,
  parameter int XLEN     = 32,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_i,
  input  xclass_e                  cls_i,
  input  logic [LVL_W-1:0]         lvl_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [XLEN-1:0]          ps_i,
  output logic [XLEN*NLVL-1:0]     epc_o,
  output logic [XLEN*(NLVL-1)-1:0] eps_o,
  output logic [XLEN-1:0]          depc_o
);

  logic [NLVL:1] epc_we;
  logic [NLVL:2] eps_we;
  logic          depc_we;
  logic          l1_epc;

  // level-1 slot also receives a double exception when no dedicated register exists
  assign l1_epc = (cls_i == XC_KERNEL) || (cls_i == XC_USER) ||
                  ((cls_i == XC_DOUBLE) && !HAS_DEPC);
  assign depc_we = wr_i && (cls_i == XC_DOUBLE) && HAS_DEPC;

  generate
    for (genvar g = 1; g <= NLVL; g++) begin : g_epc
      logic [XLEN-1:0] r;
      if (g == 1) begin : g_l1
        assign epc_we[g] = wr_i && l1_epc;
      end else begin : g_hi
        assign epc_we[g] = wr_i && (cls_i == XC_HIGH) && (lvl_i == LVL_W'(g));
      end
      always_ff @(posedge clk) begin
        if (rst)            r <= '0;
        else if (epc_we[g]) r <= pc_i;
      end
      assign epc_o[XLEN*(g-1) +: XLEN] = r;
    end

    for (genvar g = 2; g <= NLVL; g++) begin : g_eps
      logic [XLEN-1:0] r;
      assign eps_we[g] = wr_i && (cls_i == XC_HIGH) && (lvl_i == LVL_W'(g));
      always_ff @(posedge clk) begin
        if (rst)            r <= '0;
        else if (eps_we[g]) r <= ps_i;
      end
      assign eps_o[XLEN*(g-2) +: XLEN] = r;
    end

    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)          r <= '0;
        else if (depc_we) r <= pc_i;
      end
      assign depc_o = r;
    end else begin : g_no_depc
      assign depc_o = '0;
    end
  endgenerate

  // R2
  one_pc_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({epc_we, depc_we}) <= 1);

  // R2
  eps_pairs_epc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eps_we) && ((eps_we == '0) || ((eps_we & epc_we[NLVL:2]) == eps_we)));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int          NLVL          = 6,
  parameter int          LVL_W         = 4,
  parameter int          XLEN          = 32,
  parameter int          MASK_W        = 32,
  parameter int          CAUSE_W       = 6,
  parameter int          L1_CAUSE      = 4,
  parameter bit          RELOC_EN      = 1'b1,
  parameter bit          HAS_DEPC      = 1'b1,
  parameter logic [31:0] DEF_VECBASE   = 32'h4000_0000,
  parameter logic [31:0] HI_VEC_OFS    = 32'h0000_0180,
  parameter logic [31:0] HI_VEC_STRIDE = 32'h0000_0040,
  parameter logic [31:0] KER_VEC_OFS   = 32'h0000_0300,
  parameter logic [31:0] USR_VEC_OFS   = 32'h0000_0340,
  parameter logic [31:0] DBL_VEC_OFS   = 32'h0000_03C0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       eval_i,
  input  logic [LVL_W-1:0]           lvl_i,
  input  logic [LVL_W-1:0]           cur_lvl_i,
  input  logic [MASK_W-1:0]          pend_i,
  input  logic [MASK_W-1:0]          en_i,
  input  logic [MASK_W*(NLVL+1)-1:0] lvl_mask_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [XLEN-1:0]            ps_i,
  input  logic [XLEN-1:0]            vecbase_i,
  output logic                       taken_o,
  output logic [2:0]                 class_o,
  output logic [XLEN-1:0]            ps_o,
  output logic [XLEN-1:0]            pc_o,
  output logic [CAUSE_W-1:0]         cause_o,
  output logic [XLEN*NLVL-1:0]       epc_o,
  output logic [XLEN*(NLVL-1)-1:0]   eps_o,
  output logic [XLEN-1:0]            depc_o
);

  decision_t       dec;
  logic            fire;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] ps_next;
  logic            taken_q;
  xclass_e         cls_q;
  logic [XLEN-1:0] ps_q;
  logic [XLEN-1:0] pc_q;
  logic [CAUSE_W-1:0] cause_q;

  irq_qualify #(
    .NLVL(NLVL), .LVL_W(LVL_W), .MASK_W(MASK_W)
  ) u_qual (
    .lvl_i    (lvl_i),
    .cur_lvl_i(cur_lvl_i),
    .tbl_i    (lvl_mask_i),
    .pend_i   (pend_i),
    .en_i     (en_i),
    .excm_i   (ps_i[PS_EXCM_B]),
    .um_i     (ps_i[PS_UM_B]),
    .dec_o    (dec)
  );

  irq_vector_sel #(
    .XLEN(XLEN), .LVL_W(LVL_W), .RELOC_EN(RELOC_EN), .DEF_VECBASE(DEF_VECBASE),
    .HI_VEC_OFS(HI_VEC_OFS), .HI_VEC_STRIDE(HI_VEC_STRIDE),
    .KER_VEC_OFS(KER_VEC_OFS), .USR_VEC_OFS(USR_VEC_OFS), .DBL_VEC_OFS(DBL_VEC_OFS)
  ) u_vec (
    .cls_i    (dec.cls),
    .lvl_i    (lvl_i),
    .vecbase_i(vecbase_i),
    .target_o (target)
  );

  assign fire = eval_i && dec.take;

  irq_save_bank #(
    .NLVL(NLVL), .LVL_W(LVL_W), .XLEN(XLEN), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (fire),
    .cls_i (dec.cls),
    .lvl_i (lvl_i),
    .pc_i  (pc_i),
    .ps_i  (ps_i),
    .epc_o (epc_o),
    .eps_o (eps_o),
    .depc_o(depc_o)
  );

  always_comb begin
    ps_next = ps_i;
    ps_next[PS_EXCM_B] = 1'b1;
    if (dec.cls == XC_HIGH) begin
      ps_next[PS_LVL_W-1:0] = PS_LVL_W'(lvl_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= 1'b0;
      cls_q   <= XC_NONE;
      ps_q    <= '0;
      pc_q    <= '0;
      cause_q <= '0;
    end else begin
      taken_q <= fire;
      if (fire) begin
        cls_q <= dec.cls;
        ps_q  <= ps_next;
        pc_q  <= target;
        if (dec.cls != XC_HIGH) cause_q <= CAUSE_W'(L1_CAUSE);
      end
    end
  end

  assign taken_o = taken_q;
  assign class_o = cls_q;
  assign ps_o    = ps_q;
  assign pc_o    = pc_q;
  assign cause_o = cause_q;

  // R1
  take_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ($past(eval_i) && ($past(lvl_i) > $past(cur_lvl_i)) &&
                 ($past(lvl_i) <= LVL_W'(NLVL))));

  // R3
  high_ps_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == XC_HIGH) |->
      (ps_o[PS_LVL_W-1:0] == PS_LVL_W'($past(lvl_i)) && ps_o[PS_EXCM_B]));

  // R8
  l1_sets_excm_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ps_o[PS_EXCM_B]);

  // R6
  double_src_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == XC_DOUBLE) |-> $past(ps_i[PS_EXCM_B]));

  // R7
  user_src_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && class_o == XC_USER) |-> ($past(ps_i[PS_UM_B]) && !$past(ps_i[PS_EXCM_B])));

  // R9
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(epc_o) && $stable(eps_o) && $stable(depc_o) &&
                  $stable(cause_o) && $stable(ps_o) && $stable(pc_o)));

endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;

  localparam int NLVL = 6;
  localparam logic [31:0] DEFB = 32'h4000_0000;
  localparam logic [31:0] VB   = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        eval_i = 1'b0;
  logic [3:0]  lvl_i = '0, cur_i = '0;
  logic [31:0] pend_i = '0, en_i = '0, pc_i = '0, ps_i = '0, vb_i = VB;
  logic [32*(NLVL+1)-1:0] tbl;

  logic        ta, tb_;
  logic [2:0]  ca, cb;
  logic [31:0] psa, psb, pca, pcb, da, db;
  logic [5:0]  cza, czb;
  logic [32*NLVL-1:0]     epa, epb;
  logic [32*(NLVL-1)-1:0] esa, esb;

  irq_dispatch u_dut (
    .clk(clk), .rst(rst), .eval_i(eval_i), .lvl_i(lvl_i), .cur_lvl_i(cur_i),
    .pend_i(pend_i), .en_i(en_i), .lvl_mask_i(tbl), .pc_i(pc_i), .ps_i(ps_i),
    .vecbase_i(vb_i), .taken_o(ta), .class_o(ca), .ps_o(psa), .pc_o(pca),
    .cause_o(cza), .epc_o(epa), .eps_o(esa), .depc_o(da));

  irq_dispatch #(.RELOC_EN(1'b0), .HAS_DEPC(1'b0)) u_dut_fixed (
    .clk(clk), .rst(rst), .eval_i(eval_i), .lvl_i(lvl_i), .cur_lvl_i(cur_i),
    .pend_i(pend_i), .en_i(en_i), .lvl_mask_i(tbl), .pc_i(pc_i), .ps_i(ps_i),
    .vecbase_i(vb_i), .taken_o(tb_), .class_o(cb), .ps_o(psb), .pc_o(pcb),
    .cause_o(czb), .epc_o(epb), .eps_o(esb), .depc_o(db));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench-side model of both instances
  logic [31:0] m_epc_a [1:NLVL], m_epc_b [1:NLVL];
  logic [31:0] m_eps_a [2:NLVL], m_eps_b [2:NLVL];
  logic [31:0] m_depc, m_ps_a, m_ps_b, m_pc_a, m_pc_b;
  logic [5:0]  m_cz;
  logic [2:0]  m_cls;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req, bit exp_taken);
    chk({req, " R1/R9 taken"}, {31'd0, ta}, {31'd0, exp_taken});
    chk({req, " R1/R9 taken fixed"}, {31'd0, tb_}, {31'd0, exp_taken});
    chk({req, " R7 class"}, {29'd0, ca}, {29'd0, m_cls});
    chk({req, " R7 class fixed"}, {29'd0, cb}, {29'd0, m_cls});
    chk({req, " R3/R8 ps"}, psa, m_ps_a);
    chk({req, " R3/R8 ps fixed"}, psb, m_ps_b);
    chk({req, " R4/R8 pc"}, pca, m_pc_a);
    chk({req, " R4/R8 pc fixed"}, pcb, m_pc_b);
    chk({req, " R5 cause"}, {26'd0, cza}, {26'd0, m_cz});
    chk({req, " R5 cause fixed"}, {26'd0, czb}, {26'd0, m_cz});
    chk({req, " R6 depc"}, da, m_depc);
    chk({req, " R6 depc fixed"}, db, 32'd0);
    for (int l = 1; l <= NLVL; l++) begin
      chk({req, " R2 epc"}, epa[32*(l-1) +: 32], m_epc_a[l]);
      chk({req, " R2 epc fixed"}, epb[32*(l-1) +: 32], m_epc_b[l]);
    end
    for (int l = 2; l <= NLVL; l++) begin
      chk({req, " R2 eps"}, esa[32*(l-2) +: 32], m_eps_a[l]);
      chk({req, " R2 eps fixed"}, esb[32*(l-2) +: 32], m_eps_b[l]);
    end
  endtask

  task automatic apply(string req, int lvl, int cur, logic [31:0] pend,
                       logic [31:0] en, logic [31:0] ps, logic [31:0] pc);
    bit tk;
    logic [31:0] hit;
    @(negedge clk);
    lvl_i = 4'(lvl); cur_i = 4'(cur); pend_i = pend; en_i = en;
    ps_i = ps; pc_i = pc; eval_i = 1'b1;
    hit = (lvl <= NLVL) ? (tbl[32*lvl +: 32] & pend & en) : 32'd0;
    tk = (lvl > cur) && (lvl <= NLVL) && (hit != 0);
    if (tk) begin
      if (lvl > 1) begin
        m_cls = 3'd1;
        m_epc_a[lvl] = pc; m_epc_b[lvl] = pc;
        m_eps_a[lvl] = ps; m_eps_b[lvl] = ps;
        m_ps_a = (ps & ~32'h1F) | 32'h10 | 32'(lvl);
        m_pc_a = VB + 32'h180 + 32'(lvl) * 32'h40;
        m_pc_b = DEFB + 32'h180 + 32'(lvl) * 32'h40;
      end else begin
        m_cz = 6'd4;
        m_ps_a = ps | 32'h10;
        if (ps[4]) begin
          m_cls = 3'd4; m_depc = pc; m_epc_b[1] = pc;
          m_pc_a = VB + 32'h3C0; m_pc_b = DEFB + 32'h3C0;
        end else begin
          m_cls = ps[5] ? 3'd3 : 3'd2;
          m_epc_a[1] = pc; m_epc_b[1] = pc;
          m_pc_a = VB + (ps[5] ? 32'h340 : 32'h300);
          m_pc_b = DEFB + (ps[5] ? 32'h340 : 32'h300);
        end
      end
      m_ps_b = m_ps_a;
    end
    @(negedge clk);
    eval_i = 1'b0;
    compare_all(req, tk);
    @(negedge clk);
    compare_all({req, " hold"}, 1'b0);
  endtask

  initial begin
    for (int l = 0; l <= NLVL; l++) tbl[32*l +: 32] = (32'd1 << l) | (32'd1 << (l + 8));
    for (int l = 1; l <= NLVL; l++) begin m_epc_a[l] = '0; m_epc_b[l] = '0; end
    for (int l = 2; l <= NLVL; l++) begin m_eps_a[l] = '0; m_eps_b[l] = '0; end
    m_depc = '0; m_ps_a = '0; m_ps_b = '0; m_pc_a = '0; m_pc_b = '0;
    m_cz = '0; m_cls = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all("R10 reset", 1'b0);

    // full level sweep against current levels; status bits cycle EXCM/UM
    for (int l = 0; l < 16; l++) begin
      for (int c = 0; c < 8; c++) begin
        int it = l * 8 + c;
        apply("R1 sweep", l, c, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
              32'hA5C3_0000 | (32'(it % 4) << 4) | 32'(c), 32'h1000_0000 + 32'(it) * 4);
      end
    end

    // mask gating: pending without enable, enable without pending, other bit
    apply("R1 no enable", 3, 0, 32'h0000_0008, 32'h0000_0000, 32'h0, 32'h5000_0000);
    apply("R1 no pending", 3, 0, 32'h0000_0000, 32'h0000_0808, 32'h0, 32'h5000_0004);
    apply("R1 unrelated bit", 3, 0, 32'h0000_0010, 32'hFFFF_FFFF, 32'h0, 32'h5000_0008);
    apply("R1 upper mask bit", 3, 0, 32'h0000_0800, 32'h0000_0800, 32'h7, 32'h5000_000C);
    apply("R5 high keeps cause", 6, 5, 32'h0000_0040, 32'h0000_0040, 32'h3F, 32'h5000_0010);
    apply("R6 double", 1, 0, 32'h2, 32'h2, 32'h30, 32'h5000_0014);
    apply("R7 user", 1, 0, 32'h2, 32'h2, 32'h20, 32'h5000_0018);
    apply("R7 kernel", 1, 0, 32'h2, 32'h2, 32'h00, 32'h5000_001C);
    apply("R1 level above config", 7, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h5000_0020);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule